// File: doc/BRIEF.md
# Hardware priority ready-task scheduler

This block keeps a table of task records and answers, at all times, which ready task has the highest priority. Each record holds a small status word, an 8-bit priority, a 16-bit delay count and an 8-bit event identifier. Software reaches every field on its own through a flat register map, using the record number and a field selector.

A task counts as ready only when it is in use and is neither waiting on time, nor pending on an event, nor suspended. The block tests every record for readiness in parallel. The ready bits and priorities then pass through a balanced binary tree of two-input compare cells. Each cell forwards the better of its two inputs, together with the OR of their ready bits. The root of the tree gives the index of the winning record and a found flag.

The delay and event-ID fields are storage only in this block. Only their matching status bits affect readiness.

Top module: `task_sched_top`

## Requirements
- R1: After reset every field of every record reads as zero, `sel_found` is 0 and `sel_idx` is 0.
- R2: The status field has bit 0 = in use, bit 1 = delayed, bit 2 = event pending and bit 3 = suspended. A record is ready only when bit 0 is 1 and bits 1, 2 and 3 are all 0.
- R3: When at least one record is ready, `sel_found` is 1 and `sel_idx` names a ready record. No other ready record has a numerically larger priority.
- R4: When several ready records share the top priority, `sel_idx` names the one with the lowest record number.
- R5: When no record is ready, `sel_found` is 0 and `sel_idx` is 0.
- R6: Address bits [7:2] select the record and bits [1:0] select the field: 0 = status, 1 = priority, 2 = delay, 3 = event ID. `rdata` shows the addressed field zero-extended, combinationally from `addr`.
- R7: A write stores the low bits of `wdata` that the field is wide enough for (status 4, priority 8, delay 16, event ID 8) at the clock edge where `wr_en` is high. The stored value is visible from the next cycle. Writes to the delay and event-ID fields do not change the selection.
- R8: The selection is combinational from the table, so `sel_idx` and `sel_found` reflect a write in the cycle right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Record number [7:2] and field selector [1:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Addressed field, zero-extended |
| sel_idx | output | 6 | Record number of the highest-priority ready task |
| sel_found | output | 1 | At least one record is ready |

## Verification
A write is stored at the rising edge where `wr_en` is high. The selection and any read of that field are due one cycle after the write data is presented, with no added delay. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and samples at the next falling edge. A read has no clock in its path, so the bench samples `rdata` a short settle time after it changes `addr`.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int STATUS_W = 4;
  localparam int DELAY_W  = 16;
  localparam int EVID_W   = 8;

  localparam int ST_INUSE   = 0;
  localparam int ST_DELAYED = 1;
  localparam int ST_EVENT   = 2;
  localparam int ST_SUSP    = 3;

  typedef enum logic [1:0] {
    FLD_STATUS = 2'd0,
    FLD_PRIO   = 2'd1,
    FLD_DELAY  = 2'd2,
    FLD_EVID   = 2'd3
  } field_e;

  // Ready test for one record: in use and not blocked for any reason.
  function automatic logic task_ready(input logic [STATUS_W-1:0] st);
    return st[ST_INUSE] & ~(st[ST_DELAYED] | st[ST_EVENT] | st[ST_SUSP]);
  endfunction

endpackage

// File: rtl/sched_record_file.sv
module sched_record_file
  import sched_pkg::*;
#(
  parameter int N      = 64,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(N),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [N-1:0]        ready_vec,
  output logic [N*PRIO_W-1:0] prio_flat
);

  logic [STATUS_W-1:0] st_q    [N];
  logic [PRIO_W-1:0]   prio_q  [N];
  logic [DELAY_W-1:0]  delay_q [N];
  logic [EVID_W-1:0]   evid_q  [N];

  logic [IDX_W-1:0] rec;
  field_e           fld;

  assign rec = addr[ADDR_W-1:2];
  assign fld = field_e'(addr[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        st_q[k]    <= '0;
        prio_q[k]  <= '0;
        delay_q[k] <= '0;
        evid_q[k]  <= '0;
      end
    end else if (wr_en) begin
      case (fld)
        FLD_STATUS: st_q[rec]    <= wdata[STATUS_W-1:0];
        FLD_PRIO:   prio_q[rec]  <= wdata[PRIO_W-1:0];
        FLD_DELAY:  delay_q[rec] <= wdata[DELAY_W-1:0];
        default:    evid_q[rec]  <= wdata[EVID_W-1:0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (fld)
      FLD_STATUS: rdata[STATUS_W-1:0] = st_q[rec];
      FLD_PRIO:   rdata[PRIO_W-1:0]   = prio_q[rec];
      FLD_DELAY:  rdata[DELAY_W-1:0]  = delay_q[rec];
      default:    rdata[EVID_W-1:0]   = evid_q[rec];
    endcase
  end

  // Upper write-data bits beyond the widest field are never stored.
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:DELAY_W];

  for (genvar k = 0; k < N; k++) begin : g_ready
    assign ready_vec[k]                  = task_ready(st_q[k]);
    assign prio_flat[k*PRIO_W +: PRIO_W] = prio_q[k];
  end

endmodule

// File: rtl/sched_prio_cell.sv
module sched_prio_cell #(
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              a_rdy,
  input  logic [PRIO_W-1:0] a_prio,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic              b_rdy,
  input  logic [PRIO_W-1:0] b_prio,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              o_rdy,
  output logic [PRIO_W-1:0] o_prio,
  output logic [IDX_W-1:0]  o_idx
);

  // Side a always covers the lower record numbers, so it wins a tie.
  logic take_a;
  assign take_a = a_rdy & (~b_rdy | (a_prio >= b_prio));

  assign o_rdy  = a_rdy | b_rdy;
  assign o_prio = take_a ? a_prio : b_prio;
  assign o_idx  = take_a ? a_idx  : b_idx;

endmodule

// File: rtl/sched_prio_tree.sv
module sched_prio_tree #(
  parameter int N      = 64,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(N),
  localparam int NODES = 2*N - 1
) (
  input  logic [N-1:0]        ready_vec,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                win_found,
  output logic [IDX_W-1:0]    win_idx
);

  // Heap layout: node i has children 2i+1 and 2i+2, leaves start at N-1.
  logic              nd_rdy  [NODES];
  logic [PRIO_W-1:0] nd_prio [NODES];
  logic [IDX_W-1:0]  nd_idx  [NODES];

  for (genvar k = 0; k < N; k++) begin : g_leaf
    assign nd_rdy[N-1+k]  = ready_vec[k];
    assign nd_prio[N-1+k] = prio_flat[k*PRIO_W +: PRIO_W];
    assign nd_idx[N-1+k]  = IDX_W'(k);
  end

  for (genvar i = 0; i < N-1; i++) begin : g_node
    sched_prio_cell #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cell (
      .a_rdy  (nd_rdy[2*i+1]),
      .a_prio (nd_prio[2*i+1]),
      .a_idx  (nd_idx[2*i+1]),
      .b_rdy  (nd_rdy[2*i+2]),
      .b_prio (nd_prio[2*i+2]),
      .b_idx  (nd_idx[2*i+2]),
      .o_rdy  (nd_rdy[i]),
      .o_prio (nd_prio[i]),
      .o_idx  (nd_idx[i])
    );
  end

  assign win_found = nd_rdy[0];
  assign win_idx   = nd_idx[0];

endmodule

// File: rtl/task_sched_top.sv
module task_sched_top #(
  parameter int N      = 64,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(N),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              sel_found
);

  logic [N-1:0]        rec_ready;
  logic [N*PRIO_W-1:0] rec_prio_flat;
  logic                tree_found;
  logic [IDX_W-1:0]    tree_idx;

  sched_record_file #(.N(N), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_recs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ready_vec (rec_ready),
    .prio_flat (rec_prio_flat)
  );

  sched_prio_tree #(.N(N), .PRIO_W(PRIO_W)) u_tree (
    .ready_vec (rec_ready),
    .prio_flat (rec_prio_flat),
    .win_found (tree_found),
    .win_idx   (tree_idx)
  );

  assign sel_found = tree_found;
  assign sel_idx   = tree_found ? tree_idx : '0;

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int N      = 64,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(N),
  localparam int ADDR_W = IDX_W + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [N-1:0]        ready_vec,
  input logic [N*PRIO_W-1:0] prio_flat,
  input logic [IDX_W-1:0]    sel_idx,
  input logic                sel_found
);

  logic [PRIO_W-1:0] win_prio;
  logic              has_higher;
  logic              has_equal_lower;

  assign win_prio = prio_flat[sel_idx*PRIO_W +: PRIO_W];

  always_comb begin
    has_higher      = 1'b0;
    has_equal_lower = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (ready_vec[k] && prio_flat[k*PRIO_W +: PRIO_W] > win_prio)
        has_higher = 1'b1;
      if (ready_vec[k] && prio_flat[k*PRIO_W +: PRIO_W] == win_prio && k < int'(sel_idx))
        has_equal_lower = 1'b1;
    end
  end

  assert_found_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found == (|ready_vec));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_found |-> sel_idx == '0);

  assert_winner_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> ready_vec[sel_idx]);

  assert_no_higher_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> !has_higher);

  assert_tie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> !has_equal_lower);

  assert_prio_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] == 2'd1) |=>
      prio_flat[$past(addr[ADDR_W-1:2])*PRIO_W +: PRIO_W] == $past(wdata[PRIO_W-1:0]));

endmodule

bind task_sched_top sched_checker #(.N(N), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .ready_vec (rec_ready),
  .prio_flat (rec_prio_flat),
  .sel_idx   (sel_idx),
  .sel_found (sel_found)
);

// File: tb/task_sched_top_bench.sv
`timescale 1ns/1ps
module task_sched_top_bench;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  sel_idx;
  logic        sel_found;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [3:0]  m_st    [N];
  logic [7:0]  m_prio  [N];
  logic [15:0] m_delay [N];
  logic [7:0]  m_evid  [N];

  always #5 clk = ~clk;

  task_sched_top u_task_sched_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sel_idx(sel_idx), .sel_found(sel_found)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Ready means in use (bit 0) with no blocking bit (1..3) set.
  function automatic bit m_ready(input int k);
    return m_st[k] == 4'b0001;
  endfunction

  // Scan upward and keep the first strictly larger priority.
  function automatic logic [6:0] m_best();
    bit found = 0;
    int best = 0;
    for (int k = 0; k < N; k++)
      if (m_ready(k) && (!found || m_prio[k] > m_prio[best])) begin
        found = 1;
        best = k;
      end
    return {found, 6'(best)};
  endfunction

  function automatic logic [31:0] m_field(input int k, input int f);
    case (f)
      0: return {28'd0, m_st[k]};
      1: return {24'd0, m_prio[k]};
      2: return {16'd0, m_delay[k]};
      default: return {24'd0, m_evid[k]};
    endcase
  endfunction

  task automatic wr(input int k, input int f, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {6'(k), 2'(f)}; wdata = d;
    @(posedge clk);
    case (f)
      0: m_st[k]    = d[3:0];
      1: m_prio[k]  = d[7:0];
      2: m_delay[k] = d[15:0];
      default: m_evid[k] = d[7:0];
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_sel(input string tag);
    logic [6:0] e;
    e = m_best();
    check({tag, " found"}, {31'd0, sel_found}, {31'd0, e[6]});
    check({tag, " idx"}, {26'd0, sel_idx}, e[6] ? {26'd0, e[5:0]} : 32'd0);
  endtask

  task automatic check_rd(input string tag, input int k, input int f);
    addr = {6'(k), 2'(f)};
    #1;
    check(tag, rdata, m_field(k, f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) begin
      m_st[k] = '0; m_prio[k] = '0; m_delay[k] = '0; m_evid[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 found", {31'd0, sel_found}, 32'd0);
    check("R1 idx", {26'd0, sel_idx}, 32'd0);
    check_rd("R1 read status 0", 0, 0);
    check_rd("R1 read prio 63", 63, 1);
    check_rd("R1 read delay 17", 17, 2);
    check_rd("R1 read evid 40", 40, 3);

    // R3 / R8: single ready record
    wr(5, 1, 32'd10);
    wr(5, 0, 32'd1);
    check_sel("R8 single ready");
    check("R3 idx5", {26'd0, sel_idx}, 32'd5);
    // R4: equal priority, lower index wins
    wr(9, 1, 32'd10);
    wr(9, 0, 32'd1);
    check("R4 tie", {26'd0, sel_idx}, 32'd5);
    wr(9, 1, 32'd11);
    check("R3 higher wins", {26'd0, sel_idx}, 32'd9);
    // R2: each blocking bit, and not in use
    wr(9, 0, 32'h3); check("R2 delayed", {26'd0, sel_idx}, 32'd5);
    wr(9, 0, 32'h5); check("R2 event", {26'd0, sel_idx}, 32'd5);
    wr(9, 0, 32'h9); check("R2 suspended", {26'd0, sel_idx}, 32'd5);
    wr(9, 0, 32'h0); check("R2 not in use", {26'd0, sel_idx}, 32'd5);
    wr(9, 0, 32'hE); check("R2 blocked no inuse", {26'd0, sel_idx}, 32'd5);
    // R7: delay / event id writes leave selection alone, truncation
    wr(5, 2, 32'hFFFF_ABCD);
    wr(5, 3, 32'h1234_56EF);
    check_sel("R7 no effect");
    check_rd("R7 delay trunc", 5, 2);
    check_rd("R7 evid trunc", 5, 3);
    wr(9, 0, 32'hFFFF_FFF1);
    check_rd("R7 status trunc", 9, 0);
    check("R7 status trunc sel", {26'd0, sel_idx}, 32'd9);
    // boundary records 0 and 63
    wr(63, 1, 32'd255); wr(63, 0, 32'd1);
    check("R3 top record", {26'd0, sel_idx}, 32'd63);
    wr(0, 1, 32'd255); wr(0, 0, 32'd1);
    check("R4 rec0 tie rec63", {26'd0, sel_idx}, 32'd0);
    check_rd("R6 read prio 0", 0, 1);
    // R5: clear everything
    for (int k = 0; k < N; k++) if (m_st[k] != 0) wr(k, 0, 32'd0);
    check_sel("R5 none ready");
    check("R5 idx zero", {26'd0, sel_idx}, 32'd0);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int k, f;
      logic [31:0] d;
      k = $urandom_range(0, N-1);
      f = $urandom_range(0, 3);
      d = $urandom;
      if (f == 0 && $urandom_range(0, 1) == 1) d = 32'd1;
      if (f == 1 && $urandom_range(0, 1) == 1) d[7:0] = 8'($urandom_range(0, 7));
      wr(k, f, d);
      check_sel("R3 random");
      check_rd("R6 random read", $urandom_range(0, N-1), $urandom_range(0, 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule